// File: doc/BRIEF.md
# DMA Interrupt Status Word with Stacked Read-Clear

This block holds the DMA interrupt status that software sees as one 8-bit read-only word. DMA sources raise one-cycle condition pulses on `evt_i`. When the word holds nothing, a pulse is captured into the word directly. While the word is occupied, further conditions are held in a small queue of captured vectors behind it.

A read, signalled by a one-cycle `rd_i` strobe, returns the word combinationally during that cycle. It then clears every interrupt bit that was set. If vectors are waiting in the queue, the oldest one is loaded one cycle after the read. The summary flag `pend_o` feeds a global interrupt status register. It is the OR of the presented bits whose enable bit in `mask_i` is 1.

Bit 7 of the word is a live view of the DMA FIFO-empty input and never raises an interrupt. Software is expected to leave at least 12 clock periods between consecutive status reads. The block does not enforce this spacing.

Top module: `dma_irq_status`

## Requirements
- R1: After reset the word holds no interrupt bits and `pend_o` is 0, so with `fifo_empty_i`=1 the word reads 0x80.
- R2: Bit layout: bit 7 = live FIFO empty, bit 6 = master data parity error, bit 5 = bus fault, bit 4 = abort, bit 3 = single step, bit 2 = reserved (always reads 0), bit 1 = script interrupt instruction, bit 0 = illegal instruction. `evt_i` uses the same positions. `evt_i` bits 7 and 2 are ignored. Bit 7 follows `fifo_empty_i` in the same cycle.
- R3: An event that arrives while the word is empty and no read is in progress appears in the word on the next cycle.
- R4: `rdata_o` shows the word during the `rd_i` cycle. When the queue is empty, the word is clear on the next cycle unless an event arrived with the read.
- R5: Events that arrive while the word is non-zero leave the word unchanged and are queued. After a read, the oldest queued vector appears two cycles after the read cycle.
- R6: An event in the same cycle as a read is not lost. It becomes the word if the queue was empty; otherwise it is queued behind the existing entries.
- R7: The queue holds 4 vectors. An event that arrives while the queue is full is ORed into the newest entry.
- R8: `pend_o` is 1 exactly when some presented interrupt bit has its `mask_i` bit at 1. Bits whose `mask_i` bit is 0 are still recorded and read back.
- R9: After a read with a non-empty queue, `pend_o` is 0 in the next cycle. It returns in the following cycle when the refilled vector has an enabled bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 8 | One-cycle interrupt condition pulses, positions as in the word |
| mask_i | input | 8 | Per-bit interrupt enable, 1 = may drive `pend_o` |
| fifo_empty_i | input | 1 | Live DMA FIFO-empty state |
| rd_i | input | 1 | One-cycle read-and-clear strobe |
| rdata_o | output | 8 | Status word |
| pend_o | output | 1 | DMA interrupt pending summary |

## Verification
The bench builds the block with its default queue depth of 4. This makes the full-queue merge path reachable with a handful of events, and the test fills the queue exactly. It then drains the queue, which exposes the one-cycle refill gap and the merged newest entry in order. Mask changes made while a vector is held show that recording and signalling are separate.

// File: rtl/dma_irq_pkg.sv
package dma_irq_pkg;
  localparam int WORD_W  = 8;
  localparam int FE_BIT  = 7;
  localparam int RSV_BIT = 2;
  localparam logic [WORD_W-1:0] IRQ_BITS = 8'h7B;
endpackage

// File: rtl/irq_stack.sv
module irq_stack #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rp, wp, newest;
  logic [CW-1:0] cnt;
  logic          wr_new, wr_merge;

  function automatic logic [PW-1:0] inc(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign empty    = (cnt == '0);
  assign full     = (cnt == CW'(DEPTH));
  assign newest   = (wp == '0) ? PW'(DEPTH - 1) : wp - 1'b1;
  assign wr_new   = push && (!full || pop);
  assign wr_merge = push && full && !pop;
  assign dout     = mem[rp];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rp  <= '0;
      wp  <= '0;
      cnt <= '0;
    end else begin
      if (pop)    rp <= inc(rp);
      if (wr_new) wp <= inc(wp);
      if (wr_new && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !wr_new) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_new)        mem[wp]     <= din;
    else if (wr_merge) mem[newest] <= mem[newest] | din;
  end

  // R5
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  // R7
  merge_keeps_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> full);
endmodule

// File: rtl/dma_stat_view.sv
module dma_stat_view
  import dma_irq_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  input  logic [WORD_W-1:0] mask,
  input  logic              fifo_empty,
  output logic [WORD_W-1:0] rdata,
  output logic              pend
);
  always_comb begin
    rdata          = word & IRQ_BITS;
    rdata[FE_BIT]  = fifo_empty;
    rdata[RSV_BIT] = 1'b0;
  end

  assign pend = |(word & mask & IRQ_BITS);
endmodule

// File: rtl/dma_irq_status.sv
module dma_irq_status
  import dma_irq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] evt_i,
  input  logic [WORD_W-1:0] mask_i,
  input  logic              fifo_empty_i,
  input  logic              rd_i,
  output logic [WORD_W-1:0] rdata_o,
  output logic              pend_o
);
  logic [WORD_W-1:0] cur, cur_d, evt, stk_dout;
  logic              refill_q, refill_d;
  logic              push, pop, stk_empty, stk_full;

  assign evt = evt_i & IRQ_BITS;

  always_comb begin
    cur_d    = cur;
    push     = 1'b0;
    pop      = 1'b0;
    refill_d = 1'b0;
    if (refill_q) begin
      cur_d = stk_dout;
      pop   = 1'b1;
      push  = |evt;
    end else if (rd_i) begin
      if (stk_empty) begin
        cur_d = evt;
      end else begin
        cur_d    = '0;
        refill_d = 1'b1;
        push     = |evt;
      end
    end else if (cur == '0) begin
      cur_d = evt;
    end else begin
      push = |evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur      <= '0;
      refill_q <= 1'b0;
    end else begin
      cur      <= cur_d;
      refill_q <= refill_d;
    end
  end

  irq_stack #(.W(WORD_W), .DEPTH(DEPTH)) u_stack (
    .clk   (clk),
    .rst_n (rst_n),
    .push  (push),
    .pop   (pop),
    .din   (evt),
    .dout  (stk_dout),
    .empty (stk_empty),
    .full  (stk_full)
  );

  dma_stat_view u_view (
    .word       (cur),
    .mask       (mask_i),
    .fifo_empty (fifo_empty_i),
    .rdata      (rdata_o),
    .pend       (pend_o)
  );

  // R5
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!refill_q && !rd_i && cur != '0) |=> (cur == $past(cur)));

  // R4
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !refill_q && stk_empty && evt == '0) |=> (cur == '0));

  // R5
  refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    refill_q |=> (cur != '0));

  // R9
  pend_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && !refill_q && !stk_empty) |=> !pend_o);
endmodule

// File: tb/dma_irq_status_tb.sv
`timescale 1ns/1ps
module dma_irq_status_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] evt_i = '0, mask_i = 8'hFF, rdata_o;
  logic       fifo_empty_i = 1'b1, rd_i = 1'b0, pend_o;
  int         errors = 0, checks = 0;
  bit         done = 0;

  always #10 clk = ~clk;

  dma_irq_status u_dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .mask_i(mask_i),
    .fifo_empty_i(fifo_empty_i), .rd_i(rd_i), .rdata_o(rdata_o), .pend_o(pend_o)
  );

  // {req, rd, evt, mask, fe, exp_rdata, exp_pend}
  typedef struct packed {
    logic [3:0] req; logic rd; logic [7:0] evt; logic [7:0] mask;
    logic fe; logic [7:0] exp; logic pend;
  } vec_t;

  localparam vec_t VECS [18] = '{
    '{4'd1, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h80, 1'b0}, // R1 idle after reset
    '{4'd3, 1'b0, 8'h01, 8'hFF, 1'b1, 8'h80, 1'b0}, // R3 event enters
    '{4'd3, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h81, 1'b1}, // R3 visible next cycle
    '{4'd5, 1'b0, 8'h20, 8'hFF, 1'b1, 8'h81, 1'b1}, // R5 event queued
    '{4'd5, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h81, 1'b1}, // R5 word unchanged
    '{4'd4, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h81, 1'b1}, // R4 read returns word
    '{4'd9, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h80, 1'b0}, // R9 gap cycle
    '{4'd5, 1'b0, 8'h00, 8'hFF, 1'b1, 8'hA0, 1'b1}, // R5 refilled vector
    '{4'd6, 1'b1, 8'h08, 8'hFF, 1'b1, 8'hA0, 1'b1}, // R6 read plus event
    '{4'd6, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h88, 1'b1}, // R6 event kept
    '{4'd4, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h88, 1'b1}, // R4 read
    '{4'd2, 1'b0, 8'h84, 8'hFF, 1'b1, 8'h80, 1'b0}, // R2 cleared, bits 7/2 offered
    '{4'd2, 1'b0, 8'h00, 8'hFF, 1'b0, 8'h00, 1'b0}, // R2 ignored bits, live FE
    '{4'd8, 1'b0, 8'h02, 8'h00, 1'b1, 8'h80, 1'b0}, // R8 masked event
    '{4'd8, 1'b0, 8'h00, 8'h00, 1'b1, 8'h82, 1'b0}, // R8 recorded, no pend
    '{4'd8, 1'b0, 8'h00, 8'h02, 1'b1, 8'h82, 1'b1}, // R8 enable raises pend
    '{4'd4, 1'b1, 8'h00, 8'hFF, 1'b1, 8'h82, 1'b1}, // R4 read
    '{4'd4, 1'b0, 8'h00, 8'hFF, 1'b1, 8'h80, 1'b0}  // R4 cleared
  };

  task automatic check(input int req, input logic [7:0] exp, input logic ep);
    checks++;
    if (rdata_o !== exp || pend_o !== ep) begin
      errors++;
      $display("FAIL R%0d: rdata=%h pend=%b expected rdata=%h pend=%b",
               req, rdata_o, pend_o, exp, ep);
    end
  endtask

  task automatic cyc(input logic rd, input logic [7:0] ev);
    rd_i = rd; evt_i = ev;
    @(posedge clk); @(negedge clk);
    rd_i = 1'b0; evt_i = '0;
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; rd_i = 1'b0; evt_i = '0; mask_i = 8'hFF; fifo_empty_i = 1'b1;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    #1;
  endtask

  initial begin
    do_reset();
    check(1, 8'h80, 1'b0); // R1 reset state
    foreach (VECS[i]) begin
      rd_i = VECS[i].rd; evt_i = VECS[i].evt; mask_i = VECS[i].mask;
      fifo_empty_i = VECS[i].fe;
      #1;
      check(int'(VECS[i].req), VECS[i].exp, VECS[i].pend);
      @(posedge clk); @(negedge clk);
    end
    rd_i = 1'b0; evt_i = '0; mask_i = 8'hFF; fifo_empty_i = 1'b1;

    // R7: fill four entries, then merge into the newest
    do_reset();
    cyc(0, 8'h01);
    cyc(0, 8'h02); cyc(0, 8'h08); cyc(0, 8'h10); cyc(0, 8'h20);
    cyc(0, 8'h40); cyc(0, 8'h01);
    check(7, 8'h81, 1'b1);
    cyc(1, 8'h00); check(9, 8'h80, 1'b0); // R9 gap
    cyc(0, 8'h00); check(7, 8'h82, 1'b1);
    cyc(1, 8'h00); cyc(0, 8'h00); check(7, 8'h88, 1'b1);
    cyc(1, 8'h00); cyc(0, 8'h00); check(7, 8'h90, 1'b1);
    cyc(1, 8'h00); cyc(0, 8'h00); check(7, 8'hE1, 1'b1); // merged 20|40|01
    cyc(1, 8'h00); check(7, 8'h80, 1'b0);
    cyc(0, 8'h00); check(7, 8'h80, 1'b0);

    // R6: event during a read with a non-empty queue is queued
    cyc(0, 8'h01); cyc(0, 8'h02);
    cyc(1, 8'h10); check(6, 8'h80, 1'b0);
    cyc(0, 8'h00); check(6, 8'h82, 1'b1);
    cyc(1, 8'h00); cyc(0, 8'h00); check(6, 8'h90, 1'b1);

    // R1: reset in the middle of activity
    cyc(0, 8'h08);
    do_reset();
    check(1, 8'h80, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule